// File: doc/BRIEF.md
# UART Interrupt Status and Request Generator

This block turns the state of a UART's transmit and receive paths into a single interrupt request. It watches the fill counts of the two 16-entry FIFOs, a once-per-bit tick from the baud generator, strobes from the receiver, and the idle flag of the transmit shifter. From these it keeps a 7-bit raw status register. Software reads that register, gates it with a mask, and clears individual bits by writing ones.

The status bits are: bit 0 receive trigger, bit 1 transmit trigger, bit 2 receive timeout, bit 3 framing error, bit 4 parity error, bit 5 break, bit 6 overrun.

Level triggers are chosen in eighths of the FIFO depth. The selector codes are 0=1/8, 1=1/4, 2=1/2, 3=3/4 and 4=7/8, and codes 5 to 7 act like code 4. When the FIFOs are turned off, the triggers follow single characters. An end-of-transmission mode replaces the transmit level trigger with a "fully drained" condition.

Top module: `uart_irq_gen`

## Requirements
- R1: While reset is low and on the first cycle after it, the raw status, the masked status and irq are all zero.
- R2: With the FIFOs enabled, bit 0 sets when the receive count is greater than or equal to the selected threshold. With depth 16 the thresholds are 2, 4, 8, 12 and 14, and selector codes 5 to 7 give 14.
- R3: With the FIFOs enabled and end-of-transmission mode off, bit 1 sets when the transmit count is less than or equal to the selected threshold. The thresholds are the same as in R2.
- R4: With the FIFOs disabled, bit 0 sets only on a character-done strobe. The receive count has no effect.
- R5: With the FIFOs disabled and end-of-transmission mode off, bit 1 sets on a rising edge of the shifter idle flag while the transmit count is 0. A steady idle flag does not set it again after a clear.
- R6: In end-of-transmission mode, bit 1 sets only while the transmit count is 0 and the shifter is idle. The level selector is ignored.
- R7: Bit 2 sets on the 32nd bit tick after the last bit-edge pulse, while the receive count is non-zero. A bit-edge pulse, or an empty receive FIFO, restarts the count.
- R8: Bit 2 is set at most once for each quiet period, so it stays clear after a write-one clear. It clears by itself one cycle after the receive count reaches 0.
- R9: A one-cycle error strobe (framing, parity, break, overrun) sets its bit the next cycle. The bit holds until a write-one clear of that bit.
- R10: If a set condition and a write-one clear of the same bit fall in one cycle, the bit stays set.
- R11: masked_status is raw status AND mask, and irq is high when any masked bit is high. Both follow a mask change without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFOs enabled |
| eot_mode | input | 1 | Transmit trigger means fully drained |
| rx_lvl_sel | input | 3 | Receive threshold code |
| tx_lvl_sel | input | 3 | Transmit threshold code |
| rx_count | input | 5 | Receive FIFO fill |
| tx_count | input | 5 | Transmit FIFO fill |
| bit_tick | input | 1 | One pulse per serial bit time |
| rx_edge | input | 1 | Receiver saw a new bit |
| rx_char_done | input | 1 | Receiver finished a character |
| rx_overrun | input | 1 | Overrun strobe |
| rx_break | input | 1 | Break strobe |
| rx_parity_err | input | 1 | Parity error strobe |
| rx_frame_err | input | 1 | Framing error strobe |
| tx_shift_idle | input | 1 | Transmit shifter empty, stop bit sent |
| mask | input | 7 | Interrupt enables per bit |
| clr_we | input | 1 | Write strobe for the clear register |
| clr_data | input | 7 | Ones clear the matching status bits |
| raw_status | output | 7 | Raw status |
| masked_status | output | 7 | Raw status gated by mask |
| irq | output | 1 | Combined interrupt request |

## Verification
A software clear and a new set of the same source can fall on the same clock edge. This happens either with an error strobe from the receiver or with a level condition that still holds. The bench provokes it by raising a break strobe in the same cycle as a write-one clear of the break bit, and it expects the bit to read back as set. The vector walk clears all bits on every step while new trigger conditions are applied, so every level check also covers the case where set wins over clear.

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
  parameter int DEPTH        = 16,
  parameter int TIMEOUT_BITS = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(TIMEOUT_BITS + 1),
  localparam int NS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          eot_mode,
  input  logic [2:0]    rx_lvl_sel,
  input  logic [2:0]    tx_lvl_sel,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          bit_tick,
  input  logic          rx_edge,
  input  logic          rx_char_done,
  input  logic          rx_overrun,
  input  logic          rx_break,
  input  logic          rx_parity_err,
  input  logic          rx_frame_err,
  input  logic          tx_shift_idle,
  input  logic [NS-1:0] mask,
  input  logic          clr_we,
  input  logic [NS-1:0] clr_data,
  output logic [NS-1:0] raw_status,
  output logic [NS-1:0] masked_status,
  output logic          irq
);

  localparam int B_RX = 0, B_TX = 1, B_TO = 2, B_FE = 3, B_PE = 4, B_BK = 5, B_OE = 6;

  function automatic logic [CW-1:0] level_of(input logic [2:0] sel);
    int eighths;
    case (sel)
      3'd0:    eighths = 1;
      3'd1:    eighths = 2;
      3'd2:    eighths = 4;
      3'd3:    eighths = 6;
      default: eighths = 7;
    endcase
    return CW'(eighths * DEPTH / 8);
  endfunction

  logic [NS-1:0] raw_q;
  logic [TW-1:0] to_cnt;
  logic          idle_q;
  logic          rx_empty, rx_set, tx_set, to_set;
  logic [NS-1:0] set_v, clr_v;

  assign rx_empty = (rx_count == '0);

  assign rx_set = fifo_en ? (rx_count >= level_of(rx_lvl_sel)) : rx_char_done;

  assign tx_set = eot_mode ? (tx_count == '0 && tx_shift_idle)
                : fifo_en  ? (tx_count <= level_of(tx_lvl_sel))
                           : (tx_shift_idle && !idle_q && tx_count == '0);

  assign to_set = bit_tick && !rx_edge && !rx_empty && to_cnt == TW'(TIMEOUT_BITS - 1);

  assign set_v = {rx_overrun, rx_break, rx_parity_err, rx_frame_err, to_set, tx_set, rx_set};
  assign clr_v = (clr_we ? clr_data : '0) | (rx_empty ? NS'(1 << B_TO) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_cnt <= '0;
      idle_q <= 1'b0;
      raw_q  <= '0;
    end else begin
      idle_q <= tx_shift_idle;
      if (rx_edge || rx_empty)
        to_cnt <= '0;
      else if (bit_tick && to_cnt != TW'(TIMEOUT_BITS))
        to_cnt <= to_cnt + 1'b1;
      raw_q <= (raw_q & ~clr_v) | set_v;
    end
  end

  assign raw_status    = raw_q;
  assign masked_status = raw_q & mask;
  assign irq           = |masked_status;

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> raw_status == '0);

  // R7
  timeout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_status[B_TO]) |-> $past(!rx_empty && bit_tick && !rx_edge));

  // R8
  timeout_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |=> !raw_status[B_TO]);

  // R9
  frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |=> raw_status[B_FE]);

  // R9
  parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_status[B_PE] && !(clr_we && clr_data[B_PE]) |=> raw_status[B_PE]);

  // R10
  overrun_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun && clr_we && clr_data[B_OE] |=> raw_status[B_OE]);

  // R6
  eot_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_mode && $rose(raw_status[B_TX]) |-> $past(tx_count == '0 && tx_shift_idle));

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_status & mask) != '0);

endmodule

// File: tb/uart_irq_gen_tb.sv
module uart_irq_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, eot_mode = 0;
  logic [2:0] rx_lvl_sel = 0, tx_lvl_sel = 0;
  logic [4:0] rx_count = 0, tx_count = 0;
  logic bit_tick = 0, rx_edge = 0, rx_char_done = 0;
  logic rx_overrun = 0, rx_break = 0, rx_parity_err = 0, rx_frame_err = 0;
  logic tx_shift_idle = 0, clr_we = 0;
  logic [6:0] mask = 0, clr_data = 0;
  logic [6:0] raw_status, masked_status;
  logic irq;
  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_gen dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .eot_mode(eot_mode),
    .rx_lvl_sel(rx_lvl_sel), .tx_lvl_sel(tx_lvl_sel),
    .rx_count(rx_count), .tx_count(tx_count), .bit_tick(bit_tick),
    .rx_edge(rx_edge), .rx_char_done(rx_char_done), .rx_overrun(rx_overrun),
    .rx_break(rx_break), .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
    .tx_shift_idle(tx_shift_idle), .mask(mask), .clr_we(clr_we), .clr_data(clr_data),
    .raw_status(raw_status), .masked_status(masked_status), .irq(irq));

  // {rx_sel, tx_sel, rx_count, tx_count, exp_rx_bit, exp_tx_bit}
  localparam logic [17:0] VEC [12] = '{
    {3'd0, 3'd0, 5'd1,  5'd2,  1'b0, 1'b1},
    {3'd0, 3'd0, 5'd2,  5'd3,  1'b1, 1'b0},
    {3'd1, 3'd1, 5'd3,  5'd4,  1'b0, 1'b1},
    {3'd1, 3'd1, 5'd4,  5'd5,  1'b1, 1'b0},
    {3'd2, 3'd2, 5'd7,  5'd8,  1'b0, 1'b1},
    {3'd2, 3'd2, 5'd8,  5'd9,  1'b1, 1'b0},
    {3'd3, 3'd3, 5'd12, 5'd12, 1'b1, 1'b1},
    {3'd3, 3'd3, 5'd11, 5'd13, 1'b0, 1'b0},
    {3'd4, 3'd4, 5'd14, 5'd14, 1'b1, 1'b1},
    {3'd4, 3'd4, 5'd13, 5'd15, 1'b0, 1'b0},
    {3'd7, 3'd7, 5'd14, 5'd15, 1'b1, 1'b0},
    {3'd4, 3'd4, 5'd16, 5'd0,  1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear(input logic [6:0] bits);
    clr_we = 1; clr_data = bits;
    cyc(1);
    clr_we = 0; clr_data = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; cyc(1);
      bit_tick = 0; cyc(1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    cyc(3);
    check("R1 raw in reset", raw_status, 0);
    check("R1 irq in reset", irq, 0);
    rst_n = 1;
    cyc(1);
    check("R1 raw after reset", raw_status, 0);

    // R2 R3 vector walk
    fifo_en = 1;
    for (int v = 0; v < 12; v++) begin
      {rx_lvl_sel, tx_lvl_sel, rx_count, tx_count} = VEC[v][17:2];
      clear(7'h7F);
      check($sformatf("R2 vec %0d", v), raw_status[0], VEC[v][1]);
      check($sformatf("R3 vec %0d", v), raw_status[1], VEC[v][0]);
    end

    // R9 R11 error strobes, mask
    rx_count = 0; tx_count = 16; rx_lvl_sel = 0; tx_lvl_sel = 0;
    clear(7'h7F);
    check("R9 quiet", raw_status, 0);
    rx_parity_err = 1; cyc(1); rx_parity_err = 0;
    check("R9 parity set", raw_status, 7'h10);
    #1 check("R11 irq masked off", irq, 0);
    mask = 7'h10;
    #1 check("R11 irq on mask", irq, 1);
    check("R11 masked", masked_status, 7'h10);
    mask = 7'h01;
    #1 check("R11 irq other mask", irq, 0);
    cyc(3);
    check("R9 parity holds", raw_status, 7'h10);
    clear(7'h10);
    check("R9 parity clear", raw_status, 0);
    rx_frame_err = 1; cyc(1); rx_frame_err = 0;
    check("R9 frame set", raw_status, 7'h08);
    rx_overrun = 1; cyc(1); rx_overrun = 0;
    clear(7'h08);
    check("R9 partial clear", raw_status, 7'h40);
    clear(7'h40);

    // R10 set and clear together
    rx_break = 1; cyc(1); rx_break = 0;
    rx_break = 1; clr_we = 1; clr_data = 7'h20;
    cyc(1);
    rx_break = 0; clr_we = 0; clr_data = 0;
    check("R10 set wins", raw_status[5], 1);
    clear(7'h20);
    check("R10 later clear", raw_status[5], 0);

    // R7 R8 receive timeout
    mask = 0; rx_lvl_sel = 4; rx_count = 1;
    rx_edge = 1; cyc(1); rx_edge = 0;
    clear(7'h7F);
    tick(31);
    check("R7 not yet at 31", raw_status[2], 0);
    tick(1);
    check("R7 fires at 32", raw_status[2], 1);
    clear(7'h04);
    tick(5);
    check("R8 one shot", raw_status[2], 0);
    rx_count = 0; cyc(1); rx_count = 1;
    tick(20);
    rx_edge = 1; cyc(1); rx_edge = 0;
    tick(31);
    check("R7 edge restarts", raw_status[2], 0);
    tick(1);
    check("R7 fires after restart", raw_status[2], 1);
    rx_count = 0; cyc(1);
    check("R8 empty clears", raw_status[2], 0);

    // R4 disabled receive
    fifo_en = 0; rx_count = 5; tx_count = 1;
    clear(7'h7F);
    check("R4 count ignored", raw_status[0], 0);
    rx_char_done = 1; cyc(1); rx_char_done = 0;
    check("R4 char sets", raw_status[0], 1);

    // R5 disabled transmit
    tx_count = 0; tx_shift_idle = 0;
    clear(7'h7F);
    check("R5 busy", raw_status[1], 0);
    tx_shift_idle = 1; cyc(1);
    check("R5 done edge", raw_status[1], 1);
    clear(7'h02);
    check("R5 no retrigger", raw_status[1], 0);

    // R6 end-of-transmission mode
    fifo_en = 1; eot_mode = 1; tx_lvl_sel = 4; tx_count = 1;
    clear(7'h7F);
    check("R6 level ignored", raw_status[1], 0);
    tx_count = 0; tx_shift_idle = 0;
    clear(7'h7F);
    check("R6 shifter busy", raw_status[1], 0);
    tx_shift_idle = 1; cyc(1);
    check("R6 drained", raw_status[1], 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule